// File: doc/BRIEF.md
# Tiled-View Address Generator

This block turns a pixel coordinate into an address inside a tiled-memory view. The caller supplies an element format, a view orientation and an (x, y) coordinate with a valid strobe. One clock later the block returns the view address and the row stride that match that format and orientation.

The format sets how wide each coordinate field is and how far the packed offset is shifted left. The orientation can mirror either axis by XOR with the field mask, and it can swap the axes. The format code and the orientation code are carried in the top five address bits. A coordinate that does not fit its field gives a zero address and raises an error flag.

Top module: `tiled_view_addr`

## Requirements
- R1: While reset is asserted, and until the first valid input after it, `out_valid`, `range_err`, `addr` and `stride` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. The results for that input appear in the same cycle.
- R3: When `in_valid` is low, `addr`, `stride` and `range_err` keep their previous values, whatever the other inputs do.
- R4: For an in-range coordinate, `addr[31:29]` equals the orientation code and `addr[28:27]` equals the format code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page).
- R5: Each format has shift pair (xs, ys): 8-bit (0,0), 16-bit (0,1), 32-bit (1,1), page (SLOT_W_BITS, SLOT_H_BITS). The x field is CW_BITS−xs bits wide and the y field is CH_BITS−ys bits wide.
- R6: If x exceeds its field mask or y exceeds its field mask, `addr` is 0 and `range_err` is 1. Otherwise `range_err` is 0.
- R7: Orientation bit 1 set XORs x with its all-ones field mask. Orientation bit 0 set does the same to y with its own mask.
- R8: With orientation bit 2 set, the offset is (x' << ybits) + y'. With it clear, the offset is (y' << xbits) + x'. Here x' and y' are the coordinates after mirroring.
- R9: The offset is shifted left by xs+ys and placed in `addr[26:0]`.
- R10: `stride` is 1 << (CH_BITS+xs) when orientation bit 2 is set, and 1 << (CW_BITS+ys) otherwise. It is computed even for an out-of-range coordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Element format code |
| orient | input | 3 | View orientation code |
| x | input | COORD_W | Pixel column |
| y | input | COORD_W | Pixel row |
| out_valid | output | 1 | Result strobe, one cycle after request |
| addr | output | 32 | View address, zero on range error |
| stride | output | 32 | Row stride in bytes for the view |
| range_err | output | 1 | Coordinate outside its field |

## Verification
The assertions assume that reset is released synchronously, that all inputs hold known values on every rising edge, and that CW_BITS+CH_BITS does not exceed 27, so the offset never reaches the code bits. The bench changes inputs only on falling edges and never drives X. Its random coordinates are drawn mostly inside the field masks for the chosen format. A smaller share go just past the masks or far beyond them, and idle cycles are mixed in with shuffled inputs.

// File: rtl/tiled_view_addr.sv
module tiled_view_addr #(
  parameter int CW_BITS     = 14,
  parameter int CH_BITS     = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int COORD_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         fmt,
  input  logic [2:0]         orient,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  output logic               out_valid,
  output logic [31:0]        addr,
  output logic [31:0]        stride,
  output logic               range_err
);
  localparam logic [5:0] CW6 = 6'(CW_BITS);
  localparam logic [5:0] CH6 = 6'(CH_BITS);

  logic [5:0]  xs, ys, xbits, ybits;
  logic [31:0] xmask, ymask, xc, yc, xm, ym, off, off_sh, addr_n, stride_n;
  logic        oob;

  always_comb begin
    unique case (fmt)
      2'd0:    begin xs = 6'd0; ys = 6'd0; end
      2'd1:    begin xs = 6'd0; ys = 6'd1; end
      2'd2:    begin xs = 6'd1; ys = 6'd1; end
      default: begin xs = 6'(SLOT_W_BITS); ys = 6'(SLOT_H_BITS); end
    endcase
  end

  assign xbits  = CW6 - xs;
  assign ybits  = CH6 - ys;
  assign xmask  = (32'd1 << xbits) - 32'd1;
  assign ymask  = (32'd1 << ybits) - 32'd1;
  assign xc     = 32'(x);
  assign yc     = 32'(y);
  assign oob    = (xc > xmask) || (yc > ymask);

  assign xm     = orient[1] ? (xc ^ xmask) : xc;
  assign ym     = orient[0] ? (yc ^ ymask) : yc;
  assign off    = orient[2] ? ((xm << ybits) + ym) : ((ym << xbits) + xm);
  assign off_sh = off << (xs + ys);

  assign addr_n   = oob ? 32'd0 :
                    ((32'(orient) << 29) | (32'(fmt) << 27) | off_sh);
  assign stride_n = orient[2] ? (32'd1 << (CH6 + xs)) : (32'd1 << (CW6 + ys));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      stride    <= '0;
      range_err <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr      <= addr_n;
        stride    <= stride_n;
        range_err <= oob;
      end
    end
  end
endmodule

// File: rtl/tiled_view_addr_chk.sv
module tiled_view_addr_chk #(
  parameter int CW_BITS = 14,
  parameter int COORD_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         fmt,
  input logic [2:0]         orient,
  input logic [COORD_W-1:0] x,
  input logic               out_valid,
  input logic [31:0]        addr,
  input logic [31:0]        stride,
  input logic               range_err
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(addr) && $stable(stride) && $stable(range_err));
  a_r4_code_bits: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (range_err || addr[31:27] == {$past(orient), $past(fmt)}));
  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> addr == 32'd0);
  a_r6_wide_x: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (32'(x) >> CW_BITS) != 0 |=> range_err);
  a_r10_stride_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(stride) == 1);
endmodule

bind tiled_view_addr tiled_view_addr_chk #(.CW_BITS(CW_BITS), .COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .orient(orient),
  .x(x), .out_valid(out_valid), .addr(addr), .stride(stride), .range_err(range_err)
);

// File: tb/tiled_view_addr_bench.sv
module tiled_view_addr_bench;
  localparam int CW = 14, CH = 13, SW = 6, SH = 6;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] fmt = 0;
  logic [2:0] orient = 0;
  logic [15:0] x = 0, y = 0;
  logic out_valid, range_err;
  logic [31:0] addr, stride;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tiled_view_addr u_tiled_view_addr (.clk, .rst_n, .in_valid, .fmt, .orient,
    .x, .y, .out_valid, .addr, .stride, .range_err);

  function automatic int shx(int f); return f == 0 ? 0 : f == 1 ? 0 : f == 2 ? 1 : SW; endfunction
  function automatic int shy(int f); return f == 0 ? 0 : f == 1 ? 1 : f == 2 ? 1 : SH; endfunction

  function automatic void model(int f, int o, int xi, int yi,
                                output bit err, output int unsigned a, output int unsigned s);
    int xb = CW - shx(f), yb = CH - shy(f);
    int unsigned xmk = (1 << xb) - 1, ymk = (1 << yb) - 1, xx = xi, yy = yi, of;
    s = (o >= 4) ? (32'd1 << (CH + shx(f))) : (32'd1 << (CW + shy(f)));
    err = (xx > xmk) || (yy > ymk);
    if (o & 2) xx = xx ^ xmk;
    if (o & 1) yy = yy ^ ymk;
    of = (o >= 4) ? (xx * (1 << yb) + yy) : (yy * (1 << xb) + xx);
    of = of << (shx(f) + shy(f));
    a = err ? 0 : ((o << 29) | (f << 27) | of);
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(int f, int o, int xi, int yi, string req);
    bit e; int unsigned a, s;
    @(negedge clk);
    in_valid = 1; fmt = 2'(f); orient = 3'(o); x = 16'(xi); y = 16'(yi);
    model(f, o, xi, yi, e, a, s);
    @(negedge clk);
    in_valid = 0;
    chk({req, " R2 valid"}, 32'(out_valid), 1);
    chk({req, " addr"}, addr, a);
    chk({req, " R10 stride"}, stride, s);
    chk({req, " R6 err"}, 32'(range_err), 32'(e));
  endtask

  initial begin
    #200000;
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    bit e; int unsigned a, s, ha, hs;
    void'($urandom(32'd12345));
    #1;
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 addr", addr, 0);
    chk("R1 stride", stride, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 err after release", 32'(range_err), 0);
    chk("R1 addr after release", addr, 0);

    for (int o = 0; o < 8; o++)
      for (int f = 0; f < 4; f++) begin
        apply(f, o, 0, 0, "R4 R7 R8 origin");
        apply(f, o, (1 << (CW - shx(f))) - 1, 3, "R5 R7 xmax");
        apply(f, o, 5, (1 << (CH - shy(f))) - 1, "R5 R8 ymax");
        apply(f, o, 1 << (CW - shx(f)), 0, "R6 x over");
        apply(f, o, 0, 1 << (CH - shy(f)), "R6 y over");
      end
    apply(0, 0, 3, 2, "R9 fmt8");
    apply(2, 0, 3, 2, "R9 fmt32");
    apply(3, 6, 17, 9, "R9 page");

    apply(1, 5, 100, 200, "R3 setup");
    ha = addr; hs = stride;
    @(negedge clk);
    fmt = 3; orient = 2; x = 16'hffff; y = 7;
    @(negedge clk);
    chk("R3 hold addr", addr, ha);
    chk("R3 hold stride", stride, hs);
    chk("R2 idle valid", 32'(out_valid), 0);

    for (int i = 0; i < 3000; i++) begin
      int f = $urandom % 4, o = $urandom % 8, xi, yi, r = $urandom % 10;
      xi = $urandom % (1 << (CW - shx(f)));
      yi = $urandom % (1 << (CH - shy(f)));
      if (r == 0) xi = (1 << (CW - shx(f))) + ($urandom % 64);
      if (r == 1) yi = $urandom % 65536;
      apply(f, o, xi, yi, "R4 R5 R7 R8 R9 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule